// File: doc/BRIEF.md
# Radix Page-Table Walker

This block turns a virtual address into a physical address by reading radix page tables out of memory, one entry per level, through a single request/response memory port. A caller pulses `start` with the address, the translation mode, the root page number, the access kind, the privilege and the status bits. The walker then either passes the address straight through, rejects it at once, or walks the tables from the most significant index downward until it reaches a leaf.

At the leaf the walker checks that the encoding is legal, that the privilege may use the page, that the access kind is allowed and that any superpage is aligned. It sets the accessed bit, and for stores the dirty bit. If the entry changes it writes it back before it finishes. The result is a physical address, read/write/execute permissions and a fault flag. All of them are presented together with a one-cycle `done` pulse and held until the next request.

Top module: `ptw_walker`

## Requirements
- R1: Mode codes are 0 bare, 1 narrow (2 levels, 10-bit indices, 4-byte entries, page number in entry bits 31:10), 8/9/10 wide (3/4/5 levels, 9-bit indices, 8-byte entries, page number in entry bits 53:10). Each level reads exactly one entry, at the current base times 4096 plus the level index times the entry size, starting with the most significant index. Any other mode code faults with no read.
- R2: When the effective privilege is machine (code 3) or the mode is bare, `done` rises one cycle after `start` with `paddr` equal to the low 56 address bits, all three permissions set, no fault and no memory access.
- R3: Privilege codes are 0 user, 1 supervisor, 3 machine. Access codes are 0 fetch, 1 load, 2 store. A load or store at machine privilege with `mprv` set uses `mpp` as its effective privilege; a fetch never does.
- R4: In the wide modes, the address bits from bit (12 + 9·levels − 1) upward must all be equal, or the request faults with no read. The narrow mode uses only the low 32 bits.
- R5: Entry bits are V0 R1 W2 X3 U4 A6 D7. An entry with V clear faults. An entry with R, W and X all clear points to the next level, and such an entry at the last level faults.
- R6: A leaf with R clear and W set is reserved and faults.
- R7: A U page faults at non-user privilege unless `sum` is set and the access is not a fetch. A page without U faults at any privilege other than supervisor.
- R8: A leaf found at level L>0 faults if the low L·index-width bits of its page number are not zero.
- R9: Loads need R, or X when `mxr` is set; stores need W; fetches need X. The reported permissions are read = R or (X and `mxr`), execute = X, and write = W and (store or D).
- R10: A successful leaf gets A set, and for a store also D. If that changes the entry, exactly one write of the new entry goes to the same address before `done`; otherwise no write is made.
- R11: A leaf at level L yields the page number (leaf page number OR the low L·index-width virtual page-number bits), followed by the 12-bit page offset.
- R12: An error response on an entry read ends the walk with a fault. Whenever `fault` is reported, `paddr` and all permissions are zero.
- R13: `done` is a single-cycle pulse, and each memory request lasts one cycle with at most one outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a translation (only while `busy` is low) |
| vaddr | input | VA_W | Virtual address |
| mode | input | 4 | Translation mode code |
| root_ppn | input | PPN_W | Page number of the root table |
| acc | input | 2 | Access kind code |
| priv | input | 2 | Current privilege code |
| mprv | input | 1 | Modify-privilege enable for loads and stores |
| mpp | input | 2 | Saved previous privilege |
| sum | input | 1 | Allow supervisor access to user pages |
| mxr | input | 1 | Make executable pages readable |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | PA_W | Byte address of the entry |
| mem_wdata | output | PTE_W | Updated entry for a write |
| mem_rvalid | input | 1 | Response strobe (read data or write acknowledge) |
| mem_err | input | 1 | Response carries an error |
| mem_rdata | input | PTE_W | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Translation failed |
| paddr | output | PA_W | Physical address |
| perm_r | output | 1 | Read allowed |
| perm_w | output | 1 | Write allowed |
| perm_x | output | 1 | Execute allowed |

## Verification
Pass-through requests and requests rejected before any read put `done` up exactly one cycle after `start`. The bench samples on the falling edge right after it drops `start` and requires `done` to be high already. A walk costs one request cycle plus the memory latency per level, and a write-back adds one more such round. The bench's memory model injects a random delay of zero to two cycles, so the bench does not count cycles for walks. It polls `done` on falling edges and compares the result, the number of reads and the write-back against a reference computed from the same table contents before the walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   localparam logic [3:0] XM_BARE = 4'd0;
   localparam logic [3:0] XM_N32  = 4'd1;
   localparam logic [3:0] XM_W39  = 4'd8;
   localparam logic [3:0] XM_W48  = 4'd9;
   localparam logic [3:0] XM_W57  = 4'd10;

   localparam logic [1:0] ACC_FETCH = 2'd0;
   localparam logic [1:0] ACC_LOAD  = 2'd1;
   localparam logic [1:0] ACC_STORE = 2'd2;

   localparam logic [1:0] PV_USER  = 2'd0;
   localparam logic [1:0] PV_SUPER = 2'd1;
   localparam logic [1:0] PV_MACH  = 2'd3;

   localparam int B_V = 0;
   localparam int B_R = 1;
   localparam int B_W = 2;
   localparam int B_X = 3;
   localparam int B_U = 4;
   localparam int B_A = 6;
   localparam int B_D = 7;
   localparam int PPN_LSB = 10;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RD, ST_RWAIT, ST_WB, ST_WWAIT
   } walk_st_e;

   typedef struct packed {
      logic       ok;
      logic       bare;
      logic       narrow;
      logic [2:0] levels;
      logic [3:0] ibits;
   } mode_info_t;
endpackage

// File: rtl/ptw_mode_dec.sv
module ptw_mode_dec
   import ptw_pkg::*;
(
   input  logic [3:0] mode,
   output mode_info_t info
);
   always_comb begin
      info = '0;
      unique case (mode)
         XM_BARE: begin info.ok = 1'b1; info.bare = 1'b1; end
         XM_N32:  begin info.ok = 1'b1; info.narrow = 1'b1; info.levels = 3'd2; info.ibits = 4'd10; end
         XM_W39:  begin info.ok = 1'b1; info.levels = 3'd3; info.ibits = 4'd9; end
         XM_W48:  begin info.ok = 1'b1; info.levels = 3'd4; info.ibits = 4'd9; end
         XM_W57:  begin info.ok = 1'b1; info.levels = 3'd5; info.ibits = 4'd9; end
         default: info = '0;
      endcase
   end
endmodule

// File: rtl/ptw_leaf_chk.sv
module ptw_leaf_chk
   import ptw_pkg::*;
#(
   parameter int PPN_W = 44
)(
   input  logic [7:0]       flags,
   input  logic [PPN_W-1:0] ppn,
   input  logic [2:0]       lvl,
   input  logic [3:0]       ibits,
   input  logic [1:0]       acc,
   input  logic [1:0]       prv,
   input  logic             sum,
   input  logic             mxr,
   output logic             bad,
   output logic             need_upd,
   output logic [7:0]       new_flags,
   output logic [PPN_W-1:0] span_mask,
   output logic             pr,
   output logic             pw,
   output logic             px
);
   logic rsvd, ubad, mis, abad;
   logic is_st;

   always_comb begin
      is_st     = (acc == ACC_STORE);
      span_mask = (PPN_W'(1) << (int'(lvl) * int'(ibits))) - PPN_W'(1);
      rsvd      = !flags[B_R] && flags[B_W];
      if (flags[B_U])
         ubad = (prv != PV_USER) && (!sum || acc == ACC_FETCH);
      else
         ubad = (prv != PV_SUPER);
      mis = (ppn & span_mask) != '0;
      unique case (acc)
         ACC_LOAD:  abad = !(flags[B_R] || (flags[B_X] && mxr));
         ACC_STORE: abad = !flags[B_W];
         default:   abad = !flags[B_X];
      endcase
      bad       = rsvd || ubad || mis || abad;
      new_flags = flags | (8'd1 << B_A) | (is_st ? (8'd1 << B_D) : 8'd0);
      need_upd  = new_flags != flags;
      pr        = flags[B_R] || (flags[B_X] && mxr);
      pw        = flags[B_W] && (is_st || flags[B_D]);
      px        = flags[B_X];
   end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int VA_W   = 64,
   parameter int PPN_W  = 44,
   parameter int PG_OFF = 12,
   parameter int PTE_W  = 64,
   parameter int PA_W   = PPN_W + PG_OFF
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [VA_W-1:0]  vaddr,
   input  logic [3:0]       mode,
   input  logic [PPN_W-1:0] root_ppn,
   input  logic [1:0]       acc,
   input  logic [1:0]       priv,
   input  logic             mprv,
   input  logic [1:0]       mpp,
   input  logic             sum,
   input  logic             mxr,
   output logic             mem_req,
   output logic             mem_we,
   output logic [PA_W-1:0]  mem_addr,
   output logic [PTE_W-1:0] mem_wdata,
   input  logic             mem_rvalid,
   input  logic             mem_err,
   input  logic [PTE_W-1:0] mem_rdata,
   output logic             busy,
   output logic             done,
   output logic             fault,
   output logic [PA_W-1:0]  paddr,
   output logic             perm_r,
   output logic             perm_w,
   output logic             perm_x
);
   localparam int MAX_LVL = 5;
   localparam int NIDX_W  = 10;
   localparam int WIDX_W  = 9;

   if (PA_W != PPN_W + PG_OFF) begin : g_bad_pa
      $error("PA_W must equal PPN_W + PG_OFF");
   end
   if (PTE_W < PPN_LSB + PPN_W) begin : g_bad_pte
      $error("PTE_W too narrow for the page number field");
   end
   if (VA_W < PG_OFF + NIDX_W * MAX_LVL || PA_W > VA_W) begin : g_bad_va
      $error("VA_W too narrow for the index fields");
   end

   walk_st_e         st;
   mode_info_t       info, info_q;
   logic [2:0]       lvl;
   logic [PPN_W-1:0] base_q;
   logic [VA_W-1:0]  va_q;
   logic [1:0]       acc_q, eff_q, eff_prv;
   logic             sum_q, mxr_q;
   logic [PTE_W-1:0] pte_q;
   logic [2:0]       perm_q;
   logic             canon;
   int               vbits;
   logic signed [VA_W-1:0] hi_bits;

   ptw_mode_dec u_dec (.mode(mode), .info(info));

   always_comb begin
      eff_prv = (priv == PV_MACH && acc != ACC_FETCH && mprv) ? mpp : priv;
      vbits   = PG_OFF + WIDX_W * int'(info.levels);
      hi_bits = $signed(vaddr) >>> (vbits - 1);
      canon   = info.narrow || (hi_bits == '0) || (hi_bits == '1);
   end

   // per-level index slices; the mode picks the narrow or wide field
   logic [NIDX_W-1:0] idx_tab [MAX_LVL];
   for (genvar g = 0; g < MAX_LVL; g++) begin : g_idx
      assign idx_tab[g] = info_q.narrow ? va_q[PG_OFF + NIDX_W*g +: NIDX_W]
                                        : {1'b0, va_q[PG_OFF + WIDX_W*g +: WIDX_W]};
   end

   logic [NIDX_W-1:0] cur_idx;
   logic [PA_W-1:0]   ent_addr;
   logic [PPN_W-1:0]  rd_ppn, span_mask;
   logic              rd_ptr, chk_bad, chk_upd, chk_r, chk_w, chk_x;
   logic [7:0]        chk_flags;
   logic [PA_W-1:0]   leaf_pa;

   always_comb begin
      cur_idx  = idx_tab[lvl];
      ent_addr = {base_q, PG_OFF'(0)} + (PA_W'(cur_idx) << (info_q.narrow ? 2 : 3));
      rd_ppn   = info_q.narrow ? PPN_W'(mem_rdata[31:PPN_LSB]) : mem_rdata[PPN_LSB +: PPN_W];
      rd_ptr   = !mem_rdata[B_R] && !mem_rdata[B_W] && !mem_rdata[B_X];
      leaf_pa  = {rd_ppn | (va_q[PG_OFF +: PPN_W] & span_mask), va_q[PG_OFF-1:0]};
   end

   ptw_leaf_chk #(.PPN_W(PPN_W)) u_chk (
      .flags(mem_rdata[7:0]), .ppn(rd_ppn), .lvl(lvl), .ibits(info_q.ibits),
      .acc(acc_q), .prv(eff_q), .sum(sum_q), .mxr(mxr_q),
      .bad(chk_bad), .need_upd(chk_upd), .new_flags(chk_flags), .span_mask(span_mask),
      .pr(chk_r), .pw(chk_w), .px(chk_x)
   );

   assign mem_req   = (st == ST_RD) || (st == ST_WB);
   assign mem_we    = (st == ST_WB);
   assign mem_addr  = ent_addr;
   assign mem_wdata = pte_q;
   assign busy      = (st != ST_IDLE);
   assign {perm_r, perm_w, perm_x} = perm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; done <= 1'b0; fault <= 1'b0; paddr <= '0; perm_q <= '0;
         lvl <= '0; base_q <= '0; va_q <= '0; acc_q <= '0; eff_q <= '0;
         sum_q <= 1'b0; mxr_q <= 1'b0; info_q <= '0; pte_q <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: if (start) begin
               va_q <= vaddr; acc_q <= acc; eff_q <= eff_prv; sum_q <= sum; mxr_q <= mxr;
               info_q <= info; base_q <= root_ppn; lvl <= info.levels - 3'd1;
               if (eff_prv == PV_MACH || (info.ok && info.bare)) begin
                  done <= 1'b1; fault <= 1'b0; paddr <= vaddr[PA_W-1:0]; perm_q <= 3'b111;
               end else if (!info.ok || !canon) begin
                  done <= 1'b1; fault <= 1'b1; paddr <= '0; perm_q <= '0;
               end else begin
                  st <= ST_RD;
               end
            end
            ST_RD: st <= ST_RWAIT;
            ST_RWAIT: if (mem_rvalid) begin
               if (mem_err || !mem_rdata[B_V] || (rd_ptr && lvl == '0) || (!rd_ptr && chk_bad)) begin
                  done <= 1'b1; fault <= 1'b1; paddr <= '0; perm_q <= '0; st <= ST_IDLE;
               end else if (rd_ptr) begin
                  base_q <= rd_ppn; lvl <= lvl - 3'd1; st <= ST_RD;
               end else begin
                  paddr  <= leaf_pa;
                  perm_q <= {chk_r, chk_w, chk_x};
                  pte_q  <= {mem_rdata[PTE_W-1:8], chk_flags};
                  if (chk_upd) st <= ST_WB;
                  else begin done <= 1'b1; fault <= 1'b0; st <= ST_IDLE; end
               end
            end
            ST_WB: st <= ST_WWAIT;
            ST_WWAIT: if (mem_rvalid) begin
               done <= 1'b1; st <= ST_IDLE;
               if (mem_err) begin fault <= 1'b1; paddr <= '0; perm_q <= '0; end
               else fault <= 1'b0;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);                                              // R13
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                    // R13
   AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[B_A]);                            // R10
   AST_WB_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && acc_q == ACC_STORE) |-> mem_wdata[B_D]);      // R10
   AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault) |-> (paddr == '0 && !perm_r && !perm_w && !perm_x)); // R12
   AST_NO_RSVD_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault && perm_w) |-> perm_r);                             // R6
   AST_BARE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mode == XM_BARE) |=> (done && !fault));          // R2
endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        start = 1'b0;
   logic [63:0] vaddr = '0;
   logic [3:0]  mode = '0;
   logic [43:0] root_ppn = '0;
   logic [1:0]  acc = '0, priv = '0, mpp = '0;
   logic        mprv = 1'b0, sum = 1'b0, mxr = 1'b0;
   logic        mem_req, mem_we, mem_rvalid = 1'b0, mem_err = 1'b0;
   logic [55:0] mem_addr, paddr;
   logic [63:0] mem_wdata, mem_rdata = '0;
   logic        busy, done, fault, perm_r, perm_w, perm_x;

   ptw_walker u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr), .mode(mode), .root_ppn(root_ppn),
      .acc(acc), .priv(priv), .mprv(mprv), .mpp(mpp), .sum(sum), .mxr(mxr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_err(mem_err), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .fault(fault), .paddr(paddr),
      .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
   );

   int n_chk = 0, n_err = 0, cyc = 0;
   logic [63:0] mem [longint unsigned];
   int rd_cnt = 0, wr_cnt = 0, err_at = 0;
   longint unsigned wr_addr = 0;
   logic [63:0] wr_val = '0;

   // memory model: one request at a time, 0..2 cycles of extra latency
   logic        pend = 1'b0, pend_we = 1'b0;
   logic [1:0]  lat = '0;
   longint unsigned pend_a = 0;
   logic [63:0] pend_d = '0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      mem_rvalid <= 1'b0;
      mem_err    <= 1'b0;
      if (mem_req) begin
         pend <= 1'b1; pend_we <= mem_we; pend_a <= longint'(mem_addr);
         pend_d <= mem_wdata; lat <= 2'($urandom % 3);
      end else if (pend) begin
         if (lat == 0) begin
            pend <= 1'b0; mem_rvalid <= 1'b1;
            if (pend_we) begin
               mem[pend_a] = pend_d; wr_cnt = wr_cnt + 1; wr_addr = pend_a; wr_val = pend_d;
            end else begin
               rd_cnt = rd_cnt + 1;
               mem_rdata <= mem.exists(pend_a) ? mem[pend_a] : 64'h0;
               mem_err <= (rd_cnt == err_at);
            end
         end else lat <= lat - 2'd1;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic void geo(input logic [3:0] md, output int lv, output int ib, output int es);
      lv = 0; ib = 9; es = 8;
      case (md)
         4'd1:  begin lv = 2; ib = 10; es = 4; end
         4'd8:  lv = 3;
         4'd9:  lv = 4;
         4'd10: lv = 5;
         default: lv = 0;
      endcase
   endfunction

   function automatic longint unsigned ent_at(input logic [43:0] b, input logic [63:0] va,
                                              input int l, input logic [3:0] md);
      int lv, ib, es;
      longint unsigned idx;
      geo(md, lv, ib, es);
      idx = longint'((va >> (12 + ib*l)) & ((64'd1 << ib) - 1));
      return longint'({b, 12'h000}) + idx * longint'(es);
   endfunction

   // independent reference of the walk, read-only on the table model
   function automatic void ref_walk(output logic f, output logic [55:0] pa, output logic [2:0] rwx,
                                    output logic wb, output longint unsigned wa,
                                    output logic [63:0] wv, output int nrd);
      int lv, ib, es, vb;
      logic [1:0] ep;
      logic [43:0] base, ppn, msk;
      logic [63:0] pte, nv;
      logic signed [63:0] hi;
      longint unsigned a;
      f = 1'b1; pa = '0; rwx = '0; wb = 1'b0; wa = 0; wv = '0; nrd = 0;
      ep = (priv == 2'd3 && acc != 2'd0 && mprv) ? mpp : priv;
      if (ep == 2'd3 || mode == 4'd0) begin f = 1'b0; pa = vaddr[55:0]; rwx = 3'b111; return; end
      geo(mode, lv, ib, es);
      if (lv == 0) return;
      if (mode != 4'd1) begin
         vb = 12 + 9*lv;
         hi = $signed(vaddr) >>> (vb - 1);
         if (hi != 0 && hi != -1) return;
      end
      base = root_ppn;
      for (int l = lv - 1; l >= 0; l--) begin
         a = ent_at(base, vaddr, l, mode);
         nrd++;
         if (nrd == err_at) return;
         pte = mem.exists(a) ? mem[a] : 64'h0;
         ppn = (mode == 4'd1) ? 44'(pte[31:10]) : pte[53:10];
         if (!pte[0]) return;
         if (pte[3:1] == 3'b000) begin base = ppn; continue; end
         if (!pte[1] && pte[2]) return;
         if (pte[4] && ep != 2'd0 && (!sum || acc == 2'd0)) return;
         if (!pte[4] && ep != 2'd1) return;
         msk = (44'd1 << (l*ib)) - 44'd1;
         if ((ppn & msk) != 0) return;
         if (acc == 2'd1 && !(pte[1] || (pte[3] && mxr))) return;
         if (acc == 2'd2 && !pte[2]) return;
         if (acc == 2'd0 && !pte[3]) return;
         nv = pte | 64'h40 | ((acc == 2'd2) ? 64'h80 : 64'h0);
         if (nv != pte) begin wb = 1'b1; wa = a; wv = nv; end
         f = 1'b0;
         pa = {ppn | (vaddr[55:12] & msk), vaddr[11:0]};
         rwx = {pte[1] || (pte[3] && mxr), pte[2] && (acc == 2'd2 || pte[7]), pte[3]};
         return;
      end
   endfunction

   // build a table chain from the top level down to leaf level leaf_l
   task automatic make_walk(input logic [3:0] md, input int leaf_l, input logic [7:0] lf, input bit align);
      int lv, ib, es, vb;
      logic [43:0] b, nx;
      logic [63:0] v;
      longint unsigned a;
      geo(md, lv, ib, es);
      mem.delete();
      v = {$urandom, $urandom};
      if (md == 4'd1) v[63:32] = '0;
      else begin vb = 12 + 9*lv; v = 64'($signed(v << (64 - vb)) >>> (64 - vb)); end
      b = 44'($urandom & 32'hF_FFFF);
      root_ppn = b; vaddr = v; mode = md;
      for (int l = lv - 1; l > leaf_l; l--) begin
         a = ent_at(b, v, l, md);
         nx = 44'($urandom & 32'hF_FFFF);
         mem[a] = (64'(nx) << 10) | 64'h1;
         b = nx;
      end
      a = ent_at(b, v, leaf_l, md);
      nx = 44'($urandom & 32'hF_FFFF);
      if (leaf_l > 0) begin
         if (align) nx = nx & ~((44'd1 << (leaf_l*ib)) - 44'd1);
         else nx[0] = 1'b1;
      end
      mem[a] = (64'(nx) << 10) | 64'(lf);
   endtask

   task automatic setp(input logic [1:0] a, input logic [1:0] p, input logic mp,
                       input logic [1:0] pp, input logic s, input logic x);
      acc = a; priv = p; mprv = mp; mpp = pp; sum = s; mxr = x;
   endtask

   task automatic run(input string tag, input int eidx);
      logic ef; logic [55:0] epa; logic [2:0] erwx; logic ewb;
      longint unsigned ewa; logic [63:0] ewv; int enrd; int t;
      err_at = eidx;
      ref_walk(ef, epa, erwx, ewb, ewa, ewv, enrd);
      @(negedge clk);
      rd_cnt = 0; wr_cnt = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      t = 0;
      while (!done && t < 500) begin @(negedge clk); t++; end
      chk(done, tag, "done seen", 64'(done), 64'd1);
      if (enrd == 0) chk(t == 0, "R2", "cycles to done", 64'(t), 64'd0);
      chk(fault == ef, tag, "fault", 64'(fault), 64'(ef));
      chk(paddr == epa, tag, "paddr", 64'(paddr), 64'(epa));
      chk({perm_r, perm_w, perm_x} == erwx, "R9", "perms", 64'({perm_r, perm_w, perm_x}), 64'(erwx));
      chk(rd_cnt == enrd, "R1", "entry reads", 64'(rd_cnt), 64'(enrd));
      chk(wr_cnt == (ewb ? 1 : 0), "R10", "writes", 64'(wr_cnt), 64'(ewb));
      if (ewb && wr_cnt == 1) begin
         chk(wr_addr == ewa, "R10", "write addr", 64'(wr_addr), 64'(ewa));
         chk(wr_val == ewv, "R10", "write value", wr_val, ewv);
      end
      err_at = 0;
   endtask

   initial begin
      while (cyc < 150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!done && !busy && !mem_req, "R13", "reset outputs", 64'({done, busy, mem_req}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 pass-through
      mem.delete(); mode = 4'd0; vaddr = 64'h0123_4567_89AB_CDEF; setp(2'd1, 2'd1, 0, 0, 0, 0); run("R2", 0);
      mode = 4'd8; setp(2'd0, 2'd3, 0, 0, 0, 0); run("R2", 0);
      // R3 effective privilege
      make_walk(4'd8, 0, 8'hCF, 1); setp(2'd1, 2'd3, 1, 2'd1, 0, 0); run("R3", 0);
      setp(2'd1, 2'd3, 1, 2'd0, 0, 0); run("R3", 0);
      setp(2'd0, 2'd3, 1, 2'd1, 0, 0); run("R3", 0);
      // R4 canonical and bad mode
      make_walk(4'd8, 0, 8'hCF, 1); vaddr[63] = ~vaddr[63]; setp(2'd1, 2'd1, 0, 0, 0, 0); run("R4", 0);
      make_walk(4'd8, 0, 8'hCF, 1); mode = 4'd5; run("R4", 0);
      // R5 invalid entry and pointer at the last level
      make_walk(4'd9, 0, 8'h01, 1); run("R5", 0);
      make_walk(4'd9, 1, 8'h00, 1); run("R5", 0);
      // R6 reserved leaves
      make_walk(4'd8, 0, 8'h05, 1); setp(2'd2, 2'd1, 0, 0, 0, 0); run("R6", 0);
      make_walk(4'd8, 0, 8'h0D, 1); setp(2'd0, 2'd1, 0, 0, 0, 0); run("R6", 0);
      // R7 user-page rules
      make_walk(4'd8, 0, 8'h53, 1); setp(2'd1, 2'd1, 0, 0, 0, 0); run("R7", 0);
      setp(2'd1, 2'd1, 0, 0, 1, 0); run("R7", 0);
      make_walk(4'd8, 0, 8'h5B, 1); setp(2'd0, 2'd1, 0, 0, 1, 0); run("R7", 0);
      make_walk(4'd8, 0, 8'h43, 1); setp(2'd1, 2'd0, 0, 0, 0, 0); run("R7", 0);
      // R8 superpage alignment
      make_walk(4'd8, 1, 8'h43, 0); setp(2'd1, 2'd1, 0, 0, 0, 0); run("R8", 0);
      make_walk(4'd8, 1, 8'h43, 1); run("R8", 0);
      // R9 execute-readable
      make_walk(4'd9, 0, 8'h49, 1); setp(2'd1, 2'd1, 0, 0, 0, 0); run("R9", 0);
      setp(2'd1, 2'd1, 0, 0, 0, 1); run("R9", 0);
      // R10 accessed/dirty write-back
      make_walk(4'd8, 0, 8'h07, 1); setp(2'd2, 2'd1, 0, 0, 0, 0); run("R10", 0);
      make_walk(4'd8, 0, 8'hC7, 1); run("R10", 0);
      make_walk(4'd8, 0, 8'h03, 1); setp(2'd1, 2'd1, 0, 0, 0, 0); run("R10", 0);
      // R11 superpage composition
      make_walk(4'd9, 2, 8'hCF, 1); run("R11", 0);
      make_walk(4'd1, 1, 8'hCF, 1); run("R11", 0);
      // R12 memory error
      make_walk(4'd8, 0, 8'hCF, 1); run("R12", 2);
      // R1 geometry across modes
      make_walk(4'd1, 0, 8'hCF, 1); run("R1", 0);
      make_walk(4'd10, 0, 8'hCF, 1); run("R1", 0);

      // constrained random mix
      for (int i = 0; i < 300; i++) begin
         logic [3:0] md; int lv, ib, es; logic [7:0] lf; logic [1:0] pv;
         case ($urandom % 4) 0: md = 4'd1; 1: md = 4'd8; 2: md = 4'd9; default: md = 4'd10; endcase
         geo(md, lv, ib, es);
         lf = 8'($urandom);
         if ($urandom % 10 != 0) lf[0] = 1'b1;
         make_walk(md, int'($urandom % lv), lf, ($urandom % 4) != 0);
         if (md != 4'd1 && $urandom % 16 == 0) vaddr[62] = ~vaddr[62];
         case ($urandom % 4) 0: pv = 2'd0; 3: pv = 2'd3; default: pv = 2'd1; endcase
         setp(2'($urandom % 3), pv, 1'($urandom), ($urandom % 2 == 0) ? 2'd0 : 2'd1,
              1'($urandom), 1'($urandom));
         run("R9", ($urandom % 8 == 0) ? int'(1 + $urandom % lv) : 0);
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule